// File: doc/BRIEF.md
# Register-Driven SPI Master

This block is an SPI master that software controls through four 32-bit registers on a simple synchronous bus. A control register carries an enable bit that drives the slave-select pin directly, plus two self-clearing strobes: one starts a write transfer and one starts a read transfer. A status register reports a busy flag. An 8-bit data register holds the command and data bits of one transfer. A configuration register selects bit order, command length, data length, the SCLK divider and master operation.

A write transfer shifts the low `cmd+dat` bits of the data register onto MOSI. In MSB-first order the command sits above the data, so it leaves first. In LSB-first order the command sits in the low bits, so it also leaves first. A read transfer sends the low `cmd` bits as the command, then holds MOSI low while it samples `dat` bits from MISO. The returned bits replace the data register, zero-extended into its low positions. SCLK follows SPI mode 0.

The shifting engine is a three-state machine: `ST_IDLE`, `ST_LOW` (SCLK low half period) and `ST_HIGH` (SCLK high half period). It has these transitions:
- `ST_IDLE -> ST_LOW` on an accepted strobe.
- `ST_LOW -> ST_HIGH` when the half-period counter reaches the divider; MISO is sampled at this edge.
- `ST_HIGH -> ST_LOW` when the counter reaches the divider and more bits remain.
- `ST_HIGH -> ST_IDLE` when the counter reaches the divider on the last bit; the read result is written back at this edge.

Register map (byte offsets on `bus_addr`):

| Offset | Register | Fields |
|--------|----------|--------|
| 0x0 | CTRL | bit 0 select enable; bit 1 start-read strobe; bit 2 start-write strobe |
| 0x4 | STAT | bit 0 busy |
| 0x8 | DATA | bits 7:0 |
| 0xC | CFG | bit 0 master; bit 1 LSB-first; bits 7:4 command length; bits 11:8 data length; bits 23:16 divider |

Top module: `spi_reg_master`

## Requirements
- R1: After reset, CTRL, STAT and DATA read 0 and CFG reads 0x00010800 (master 0, MSB-first, command length 0, data length 8, divider 1). `spi_sel`, `spi_sclk` and `spi_mosi` are low.
- R2: CTRL bit 0 is stored and drives `spi_sel` directly (0 low, 1 high) from the cycle after the write. CTRL reads back bit 0 only; bits 1 and 2 always read 0.
- R3: A start-write strobe (CTRL bit 2 = 1) in MSB-first mode sends N = cmd+dat bits. The first bit is DATA bit N-1 and the last is DATA bit 0.
- R4: A start-write strobe in LSB-first mode (CFG bit 1 = 1) sends DATA bit 0 first and DATA bit N-1 last.
- R5: SCLK idles low. Each half period lasts divider+1 clock cycles. MOSI changes only when SCLK falls or on the first cycle of a transfer. MISO is sampled when SCLK rises.
- R6: STAT bit 0 reads 1 from the cycle after an accepted strobe for exactly 2·N·(divider+1) cycles, then reads 0.
- R7: A start-read strobe (CTRL bit 1 = 1) sends the low C = cmd bits of DATA, in the configured order (MSB-first: bit C-1 first; LSB-first: bit 0 first). MOSI then stays low for dat more bits.
- R8: After a read, DATA holds the dat sampled bits in its low positions and zeros above them. In MSB-first mode the first sampled data bit goes to bit dat-1; in LSB-first mode it goes to bit 0. DATA is updated at the edge where busy clears.
- R9: With CFG bit 0 = 0, both strobes are ignored and busy stays 0.
- R10: While busy, strobes are ignored, and writes to DATA and CFG are discarded.
- R11: Strobes are ignored when cmd+dat is 0 or greater than 8.
- R12: When both strobes are written as 1 in one write, a write transfer is performed.
- R13: Bits 31:8 of DATA read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data (combinational, 0 when not enabled) |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_sel | output | 1 | Select pin, driven by the enable bit |

## Verification
The bench goes after the length boundaries: one bit, the full eight bits, and the illegal sums zero and nine. An off-by-one length check would start a transfer that should be refused, or shift the wrong number of bits. It places the read result under both bit orders with a command present, so a design that fills from the wrong end, or leaves stale command bits above the data, returns a wrong DATA value. It also writes DATA, CFG and the strobes in the middle of a transfer and starts with both strobes at once. A design that lets these through would either corrupt the outgoing bits or run a read in place of a write. Because the SCLK and MOSI waveforms are compared every cycle, a wrong half-period count or a MOSI change on a rising edge shows up in the first bit affected.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } xfer_state_t;

    // register byte offsets
    localparam int OFS_CTRL = 0;
    localparam int OFS_STAT = 4;
    localparam int OFS_DATA = 8;
    localparam int OFS_CFG  = 12;

    // control bits
    localparam int CTL_EN = 0;
    localparam int CTL_RD = 1;
    localparam int CTL_WR = 2;

    // configuration field positions
    localparam int CFG_MASTER = 0;
    localparam int CFG_LSB    = 1;
    localparam int CFG_CMD    = 4;
    localparam int CFG_DAT    = 8;
    localparam int CFG_DIV    = 16;

endpackage

// File: rtl/spi_rm_regs.sv
module spi_rm_regs
    import spi_rm_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int BUS_W   = 32,
    parameter int DATA_W  = 8,
    parameter int DIV_W   = 8,
    parameter int LEN_W   = 4,
    parameter int DIV_RST = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              busy_i,
    input  logic              fin_rd_i,
    input  logic [DATA_W-1:0] rd_value_i,
    output logic              sel_o,
    output logic              start_o,
    output logic              start_rd_o,
    output logic              lsb_o,
    output logic [LEN_W-1:0]  cmd_len_o,
    output logic [LEN_W-1:0]  dat_len_o,
    output logic [DIV_W-1:0]  div_o,
    output logic [DATA_W-1:0] data_o
);

    logic              en_q, master_q, lsb_q;
    logic [LEN_W-1:0]  cmd_q, dat_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] data_q;
    logic              wr_ctrl, wr_data, wr_cfg, len_ok, any_strobe;
    logic [LEN_W:0]    len_sum;

    assign wr_ctrl = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_data = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_DATA));
    assign wr_cfg  = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_CFG));

    assign len_sum    = {1'b0, cmd_q} + {1'b0, dat_q};
    assign len_ok     = (len_sum != '0) && (len_sum <= (LEN_W+1)'(DATA_W));
    assign any_strobe = bus_wdata[CTL_WR] || bus_wdata[CTL_RD];

    assign start_o    = wr_ctrl && any_strobe && master_q && !busy_i && len_ok;
    assign start_rd_o = start_o && !bus_wdata[CTL_WR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            master_q <= 1'b0;
            lsb_q    <= 1'b0;
            cmd_q    <= '0;
            dat_q    <= LEN_W'(DATA_W);
            div_q    <= DIV_W'(DIV_RST);
            data_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q <= bus_wdata[CTL_EN];
            end
            if (wr_cfg && !busy_i) begin
                master_q <= bus_wdata[CFG_MASTER];
                lsb_q    <= bus_wdata[CFG_LSB];
                cmd_q    <= bus_wdata[CFG_CMD +: LEN_W];
                dat_q    <= bus_wdata[CFG_DAT +: LEN_W];
                div_q    <= bus_wdata[CFG_DIV +: DIV_W];
            end
            if (fin_rd_i) begin
                data_q <= rd_value_i;
            end else if (wr_data && !busy_i) begin
                data_q <= bus_wdata[DATA_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_en) begin
            case (bus_addr)
                ADDR_W'(OFS_CTRL): bus_rdata[CTL_EN] = en_q;
                ADDR_W'(OFS_STAT): bus_rdata[0] = busy_i;
                ADDR_W'(OFS_DATA): bus_rdata[DATA_W-1:0] = data_q;
                ADDR_W'(OFS_CFG): begin
                    bus_rdata[CFG_MASTER]         = master_q;
                    bus_rdata[CFG_LSB]            = lsb_q;
                    bus_rdata[CFG_CMD +: LEN_W]   = cmd_q;
                    bus_rdata[CFG_DAT +: LEN_W]   = dat_q;
                    bus_rdata[CFG_DIV +: DIV_W]   = div_q;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    assign sel_o     = en_q;
    assign lsb_o     = lsb_q;
    assign cmd_len_o = cmd_q;
    assign dat_len_o = dat_q;
    assign div_o     = div_q;
    assign data_o    = data_q;

    // R9: a strobe with master off leaves the engine idle
    a_r9_slave_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && any_strobe && !master_q && !busy_i) |=> !busy_i);

    // R11: illegal total length never starts a transfer
    a_r11_bad_length: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && any_strobe && !len_ok && !busy_i) |=> !busy_i);

    // R10: data register frozen during a transfer except for the read result
    a_r10_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !fin_rd_i) |=> (data_q == $past(data_q)));

    // R10: configuration frozen during a transfer
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> (div_q == $past(div_q) && cmd_q == $past(cmd_q)));

endmodule

// File: rtl/spi_rm_engine.sv
module spi_rm_engine
    import spi_rm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              start_rd_i,
    input  logic              lsb_i,
    input  logic [LEN_W-1:0]  cmd_len_i,
    input  logic [LEN_W-1:0]  dat_len_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              miso_i,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              busy_o,
    output logic              fin_rd_o,
    output logic [DATA_W-1:0] rd_value_o
);

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    xfer_state_t       state_q, state_d;
    logic [DIV_W-1:0]  cnt_q, div_q;
    logic [LEN_W-1:0]  bit_q, last_q, txl_q, cmd_q, dat_q;
    logic              lsb_q, rd_q, sclk_q, mosi_q;
    logic [DATA_W-1:0] sh_q, rx_q;

    logic              half_done, last_bit, first_bit, next_bit, cap_en;
    logic [LEN_W-1:0]  start_len;
    logic [IDX_W-1:0]  cap_idx;
    int                cap_j, cap_pos;

    // bit k of a frame of len bits, taken from the low len bits of v
    function automatic logic tx_bit(logic [DATA_W-1:0] v, int len, logic lsb, int k);
        int idx;
        if (k >= len) return 1'b0;
        idx = lsb ? k : (len - 1 - k);
        return v[idx[IDX_W-1:0]];
    endfunction

    always_comb begin
        half_done = (cnt_q == div_q);
        last_bit  = (bit_q == last_q);
        start_len = start_rd_i ? cmd_len_i : (cmd_len_i + dat_len_i);
        first_bit = tx_bit(data_i, int'(start_len), lsb_i, 0);
        next_bit  = tx_bit(sh_q, int'(txl_q), lsb_q, int'(bit_q) + 1);
        cap_en    = rd_q && (bit_q >= cmd_q);
        cap_j     = int'(bit_q) - int'(cmd_q);
        cap_pos   = lsb_q ? cap_j : (int'(dat_q) - 1 - cap_j);
        cap_idx   = cap_pos[IDX_W-1:0];
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)   state_d = ST_LOW;
            ST_LOW:  if (half_done) state_d = ST_HIGH;
            ST_HIGH: if (half_done) state_d = last_bit ? ST_IDLE : ST_LOW;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and pin registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            div_q  <= '0;
            bit_q  <= '0;
            last_q <= '0;
            txl_q  <= '0;
            cmd_q  <= '0;
            dat_q  <= '0;
            lsb_q  <= 1'b0;
            rd_q   <= 1'b0;
            sh_q   <= '0;
            rx_q   <= '0;
            sclk_q <= 1'b0;
            mosi_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cnt_q  <= '0;
                        div_q  <= div_i;
                        bit_q  <= '0;
                        last_q <= cmd_len_i + dat_len_i - LEN_W'(1);
                        txl_q  <= start_len;
                        cmd_q  <= cmd_len_i;
                        dat_q  <= dat_len_i;
                        lsb_q  <= lsb_i;
                        rd_q   <= start_rd_i;
                        sh_q   <= data_i;
                        rx_q   <= '0;
                        sclk_q <= 1'b0;
                        mosi_q <= first_bit;
                    end
                end
                ST_LOW: begin
                    if (half_done) begin
                        cnt_q  <= '0;
                        sclk_q <= 1'b1;
                        if (cap_en) rx_q[cap_idx] <= miso_i;
                    end else begin
                        cnt_q <= cnt_q + DIV_W'(1);
                    end
                end
                ST_HIGH: begin
                    if (half_done) begin
                        cnt_q  <= '0;
                        sclk_q <= 1'b0;
                        if (last_bit) begin
                            mosi_q <= 1'b0;
                        end else begin
                            bit_q  <= bit_q + LEN_W'(1);
                            mosi_q <= next_bit;
                        end
                    end else begin
                        cnt_q <= cnt_q + DIV_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign sclk_o     = sclk_q;
    assign mosi_o     = mosi_q;
    assign busy_o     = (state_q != ST_IDLE);
    assign fin_rd_o   = (state_q == ST_HIGH) && half_done && last_bit && rd_q;
    assign rd_value_o = rx_q;

    // R5: serial clock low whenever no transfer runs
    a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sclk_q);

    // R5: SCLK only toggles after a full half period
    a_r5_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && ($past(state_q) != ST_IDLE) && (sclk_q != $past(sclk_q)))
        |-> ($past(cnt_q) == div_q));

    // R5: MOSI only moves on a falling SCLK inside a transfer
    a_r5_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && ($past(state_q) != ST_IDLE) && (mosi_q != $past(mosi_q)))
        |-> (!sclk_q && $past(sclk_q)));

    // R7: MOSI quiet once the command of a read has been sent
    a_r7_mosi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && rd_q && (bit_q >= txl_q)) |-> !mosi_q);

    // R6: busy only begins after an accepted start
    a_r6_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
    import spi_rm_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int BUS_W   = 32,
    parameter int DATA_W  = 8,
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_sel
);

    localparam int LEN_W = $clog2(DATA_W + 1);

    logic              busy, fin_rd, start, start_rd, lsb;
    logic [DATA_W-1:0] rd_value, data;
    logic [LEN_W-1:0]  cmd_len, dat_len;
    logic [DIV_W-1:0]  div;

    spi_rm_regs #(
        .ADDR_W (ADDR_W),
        .BUS_W  (BUS_W),
        .DATA_W (DATA_W),
        .DIV_W  (DIV_W),
        .LEN_W  (LEN_W),
        .DIV_RST(DIV_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy_i    (busy),
        .fin_rd_i  (fin_rd),
        .rd_value_i(rd_value),
        .sel_o     (spi_sel),
        .start_o   (start),
        .start_rd_o(start_rd),
        .lsb_o     (lsb),
        .cmd_len_o (cmd_len),
        .dat_len_o (dat_len),
        .div_o     (div),
        .data_o    (data)
    );

    spi_rm_engine #(
        .DATA_W(DATA_W),
        .DIV_W (DIV_W),
        .LEN_W (LEN_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .start_rd_i(start_rd),
        .lsb_i     (lsb),
        .cmd_len_i (cmd_len),
        .dat_len_i (dat_len),
        .div_i     (div),
        .data_i    (data),
        .miso_i    (spi_miso),
        .sclk_o    (spi_sclk),
        .mosi_o    (spi_mosi),
        .busy_o    (busy),
        .fin_rd_o  (fin_rd),
        .rd_value_o(rd_value)
    );

endmodule

// File: tb/spi_reg_master_test.sv
module spi_reg_master_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_mosi, spi_miso, spi_sel;

    always #10 clk = ~clk;   // 50 MHz

    spi_reg_master uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_sel(spi_sel)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";

    // reference model state
    logic [1:0] q[$];        // expected {sclk, mosi} per cycle
    int         rp = 0;
    bit         m_busy_edge = 0;
    bit         m_en = 0, m_master = 0, m_lsb = 0;
    int         m_cmd = 0, m_dat = 8, m_div = 1;
    logic [7:0] m_data = 8'h00;
    logic [7:0] rd_res = 8'h00;
    bit         rd_pend = 0;

    // slave model: presents slv MSB first, advances on each falling SCLK
    logic [7:0] slv = 8'h00;
    int         falls = 0;
    int         fall_base = 0;
    always @(negedge spi_sclk) falls++;
    assign spi_miso = ((falls - fall_base) < 8) ? slv[7 - (falls - fall_base)] : 1'b0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        logic [1:0] e;
        bit avail;
        if (rst_n) begin
            avail = (q.size() > rp);
            e = avail ? q[rp] : 2'b00;
            chk({cur_req, " R5 sclk/mosi"}, {30'b0, spi_sclk, spi_mosi}, {30'b0, e});
            chk("R2 sel pin", {31'b0, spi_sel}, {31'b0, m_en});
            if (bus_en && !bus_we && bus_addr == 4'd4)
                chk("R6 busy", bus_rdata, {31'b0, avail});
            m_busy_edge = avail;
            if (avail) rp++;
        end
    end

    function automatic logic [31:0] cfgw(bit ms, bit lsb, int c, int d, int dv);
        return {8'h00, dv[7:0], 4'h0, d[3:0], c[3:0], 2'b00, lsb, ms};
    endfunction

    task automatic push_xfer(bit is_rd);
        int n  = m_cmd + m_dat;
        int tl = is_rd ? m_cmd : n;
        int h  = m_div + 1;
        logic [7:0] res = 8'h00;
        for (int k = 0; k < n; k++) begin
            bit b = (k < tl) ? (m_lsb ? m_data[k] : m_data[tl - 1 - k]) : 1'b0;
            repeat (h) q.push_back({1'b0, b});
            repeat (h) q.push_back({1'b1, b});
        end
        fall_base = falls;
        if (is_rd) begin
            for (int j = 0; j < m_dat; j++) begin
                bit r = slv[7 - (m_cmd + j)];
                if (m_lsb) res[j] = r;
                else       res[m_dat - 1 - j] = r;
            end
            rd_res  = res;
            rd_pend = 1;
        end
    endtask

    // every bus task starts and ends just after a rising edge
    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        case (a)
            4'd0: begin
                int s = m_cmd + m_dat;
                m_en = d[0];
                if (!m_busy_edge && m_master && s >= 1 && s <= 8) begin
                    if (d[2])      push_xfer(0);
                    else if (d[1]) push_xfer(1);
                end
            end
            4'd8:  if (!m_busy_edge) m_data = d[7:0];
            4'd12: if (!m_busy_edge) begin
                m_master = d[0]; m_lsb = d[1];
                m_cmd = int'(d[7:4]); m_dat = int'(d[11:8]); m_div = int'(d[23:16]);
            end
            default: ;
        endcase
        #1 bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(logic [3:0] a, logic [31:0] exp, string req);
        bus_en = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        chk(req, bus_rdata, exp);
        @(posedge clk);
        #1 bus_en = 0;
    endtask

    task automatic wait_idle();
        bus_en = 1; bus_we = 0; bus_addr = 4'd4;
        while (q.size() > rp) @(posedge clk);
        @(posedge clk);
        #1 bus_en = 0;
        if (rd_pend) begin m_data = rd_res; rd_pend = 0; end
    endtask

    function automatic logic [31:0] cfg_rd();
        return cfgw(m_master, m_lsb, m_cmd, m_dat, m_div);
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;

        cur_req = "R1";
        rd(4'd0, 32'h0, "R1 ctrl");
        rd(4'd4, 32'h0, "R1 stat");
        rd(4'd8, 32'h0, "R1 data");
        rd(4'd12, 32'h00010800, "R1 cfg");

        cur_req = "R2";
        wr(4'd0, 32'h1);
        rd(4'd0, 32'h1, "R2 ctrl readback");
        wr(4'd0, 32'h0);

        cur_req = "R9";
        wr(4'd0, 32'h6);
        rd(4'd4, 32'h0, "R9 slave mode stat");

        cur_req = "R3";
        wr(4'd12, cfgw(1, 0, 0, 8, 1));
        wr(4'd8, 32'hA5);
        wr(4'd0, 32'h5);
        wait_idle();

        cur_req = "R10";
        wr(4'd12, cfgw(1, 0, 2, 6, 2));
        wr(4'd8, 32'hC3);
        wr(4'd0, 32'h4);
        wr(4'd8, 32'h3C);
        wr(4'd0, 32'h2);
        wr(4'd12, cfgw(1, 1, 1, 1, 0));
        wait_idle();
        rd(4'd8, 32'hC3, "R10 data kept");
        rd(4'd12, cfgw(1, 0, 2, 6, 2), "R10 cfg kept");

        cur_req = "R4";
        wr(4'd12, cfgw(1, 1, 3, 4, 0));
        wr(4'd8, 32'h5A);
        wr(4'd0, 32'h4);
        wait_idle();

        cur_req = "R7";
        slv = 8'hC3;
        wr(4'd12, cfgw(1, 0, 3, 5, 2));
        wr(4'd8, 32'h05);
        wr(4'd0, 32'h2);
        wait_idle();
        rd(4'd8, {24'h0, m_data}, "R8 msb read");

        cur_req = "R8";
        slv = 8'h96;
        wr(4'd12, cfgw(1, 1, 2, 6, 1));
        wr(4'd8, 32'h02);
        wr(4'd0, 32'h2);
        wait_idle();
        rd(4'd8, {24'h0, m_data}, "R8 lsb read");

        slv = 8'h5B;
        wr(4'd12, cfgw(1, 0, 0, 8, 3));
        wr(4'd0, 32'h2);
        wait_idle();
        rd(4'd8, {24'h0, m_data}, "R8 full byte read");

        slv = 8'h80;
        wr(4'd12, cfgw(1, 1, 0, 1, 0));
        wr(4'd8, 32'hFF);
        wr(4'd0, 32'h2);
        wait_idle();
        rd(4'd8, {24'h0, m_data}, "R8 single bit upper zero");

        cur_req = "R12";
        wr(4'd12, cfgw(1, 0, 2, 6, 0));
        wr(4'd8, 32'hFF);
        wr(4'd0, 32'h7);
        wait_idle();
        rd(4'd8, 32'hFF, "R12 data unchanged by write");

        cur_req = "R11";
        wr(4'd12, cfgw(1, 0, 0, 0, 0));
        wr(4'd0, 32'h4);
        rd(4'd4, 32'h0, "R11 zero length");
        wr(4'd12, cfgw(1, 0, 4, 5, 0));
        wr(4'd0, 32'h2);
        rd(4'd4, 32'h0, "R11 nine bits");

        cur_req = "R13";
        wr(4'd8, 32'hFFFFFF12);
        rd(4'd8, 32'h12, "R13 upper bits zero");
        wr(4'd0, 32'h6);
        rd(4'd0, 32'h0, "R2 strobes read zero");
        rd(4'd12, cfg_rd(), "R13 cfg readback");

        repeat (4) @(posedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R6 watchdog act=running exp=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule